// File: doc/BRIEF.md
# Subcarrier Edge-Count Bit Demodulator

This block recovers a card reply that carries no start marker, stop marker or length field. The controller already knows how many bits to expect and roughly when the reply begins. It pulses a start strobe at the end of its own transmission. The block then waits a programmable number of microseconds and cuts the following time into back-to-back bit windows of fixed length, 100 µs by default.

Inside each window the block counts level changes on a digitised subcarrier input, after a two-flop synchroniser. A window whose count falls strictly inside a band (default above 20 and below 60, with about 42 edges expected from a 212 kHz subcarrier) yields a 1. Any other count yields a 0. Bits are packed least significant first. They can optionally be XORed with a keystream word supplied at start. When the last window closes, the word and its bit count are presented with a one-cycle done pulse. A prescaler parameter turns the core clock into a 1 µs tick.

Top module: `edge_bit_demod`

## Requirements
- R1: Out of reset, done_o is low and data_o and nbits_o are zero.
- R2: A start_i accepted at clock edge e0 with delay D (µs) and N bits gives exactly one done_o pulse, high for the cycle after edge e0 + CLK_PER_US·(D + WIN_US·N). done_o is low on every other cycle of the frame.
- R3: rx_i is passed through two flops. One edge is counted for each clock on which the synchronised level differs from its previous sample.
- R4: A window decodes as 1 exactly when its edge count c satisfies ONE_MIN < c < ONE_MAX (defaults 20 and 60, both bounds exclusive). Any other count decodes as 0.
- R5: The per-window edge counter saturates at 2^CNT_W−1 (127 by default) and does not wrap. For example, 170 edges decode as 0.
- R6: The bit from window b (counting from 0) is placed at data_o[b], least significant bit first.
- R7: When crypt_en_i is 1 at start, received bit b is XORed with key_i[b]. When crypt_en_i is 0, key_i has no effect.
- R8: A requested count above MAX_BITS (32) is clamped to MAX_BITS, and nbits_o reports the count actually received.
- R9: data_o bits at positions nbits_o and above are zero, whatever the key and any earlier frame.
- R10: start_i and all frame inputs are ignored while a frame is in progress. Configuration is captured only at the accepted start.
- R11: A request of 0 bits gives done_o after the delay alone, with data_o = 0 and nbits_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe at the end of the reader frame |
| nbits_i | input | NB_W (6) | Expected bit count, 0..63, clamped to MAX_BITS |
| delay_us_i | input | DLY_W (16) | Wait before the first window, in µs |
| crypt_en_i | input | 1 | Enable keystream descrambling |
| key_i | input | MAX_BITS (32) | Keystream, bit b applies to window b |
| rx_i | input | 1 | Asynchronous digitised subcarrier |
| data_o | output | MAX_BITS (32) | Assembled data word |
| nbits_o | output | NB_W (6) | Number of bits received |
| done_o | output | 1 | One-cycle frame-complete pulse |

## Verification
A window boundary that drifts by even one microsecond moves the done pulse off its predicted cycle. This is visible at the end of the first frame, and the bench compares done_o against the model on every clock. A counter that wraps, or a band compare that is off by one, flips a data bit of the frame in which the bad count occurs. For this reason, counts of 20, 21, 59, 60 and 170 are placed in single windows. Stale accumulator state, or a key bit leaking above the requested length, shows up as nonzero upper bits on the next short frame.

// File: rtl/edge_demod_pkg.sv
package edge_demod_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RECV = 2'd2
  } demod_st_e;
endpackage

// File: rtl/edge_demod_sync.sv
module edge_demod_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic edge_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= rx_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  // s2 is the first safe sample; s3 holds the previous one
  assign edge_o = s2_q ^ s3_q;
endmodule

// File: rtl/edge_demod_tick.sv
module edge_demod_tick #(
  parameter int DIV = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [W-1:0] pre_q;

  assign tick_o = run_i && (pre_q == W'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pre_q <= '0;
    else if (!run_i || tick_o)  pre_q <= '0;
    else                        pre_q <= pre_q + 1'b1;
  end

  assert_tick_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((DIV > 1) && tick_o) |=> !tick_o);
endmodule

// File: rtl/edge_demod_cnt.sv
module edge_demod_cnt #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             edge_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_o <= '0;
    else if (clear_i)                     cnt_o <= '0;
    else if (edge_i && cnt_o != CNT_MAX)  cnt_o <= cnt_o + 1'b1;
  end

  assert_no_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cnt_o) == CNT_MAX && !$past(clear_i)) |-> cnt_o == CNT_MAX);
endmodule

// File: rtl/edge_bit_demod.sv
module edge_bit_demod
  import edge_demod_pkg::*;
#(
  parameter int CLK_PER_US = 50,
  parameter int WIN_US     = 100,
  parameter int MAX_BITS   = 32,
  parameter int ONE_MIN    = 20,
  parameter int ONE_MAX    = 60,
  parameter int CNT_W      = 7,
  parameter int DLY_W      = 16,
  parameter int NB_W       = $clog2(MAX_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [NB_W-1:0]     nbits_i,
  input  logic [DLY_W-1:0]    delay_us_i,
  input  logic                crypt_en_i,
  input  logic [MAX_BITS-1:0] key_i,
  input  logic                rx_i,
  output logic [MAX_BITS-1:0] data_o,
  output logic [NB_W-1:0]     nbits_o,
  output logic                done_o
);
  localparam int IDX_W = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1;
  localparam logic [CNT_W-1:0] BAND_LO = CNT_W'(ONE_MIN);
  localparam logic [CNT_W-1:0] BAND_HI = CNT_W'(ONE_MAX);
  localparam logic [DLY_W-1:0] WIN_END = DLY_W'(WIN_US - 1);
  localparam logic [NB_W-1:0]  NB_CAP  = NB_W'(MAX_BITS);

  demod_st_e            state_q;
  logic [NB_W-1:0]      nb_q, bit_q;
  logic [DLY_W-1:0]     dly_q, us_q;
  logic [MAX_BITS-1:0]  key_q, acc_q, acc_nxt;
  logic                 crypt_q;
  logic                 edge_w, tick_w, win_end_w, bit_val_w, busy_w;
  logic [CNT_W-1:0]     cnt_w;
  logic [NB_W-1:0]      nb_req_w;
  logic [IDX_W-1:0]     idx_w;

  assign busy_w    = (state_q != ST_IDLE);
  assign nb_req_w  = (nbits_i > NB_CAP) ? NB_CAP : nbits_i;
  assign win_end_w = (state_q == ST_RECV) && tick_w && (us_q == WIN_END);
  assign idx_w     = bit_q[IDX_W-1:0];
  assign bit_val_w = ((cnt_w > BAND_LO) && (cnt_w < BAND_HI)) ^ (crypt_q & key_q[idx_w]);

  always_comb begin
    acc_nxt        = acc_q;
    acc_nxt[idx_w] = bit_val_w;
  end

  edge_demod_sync i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .edge_o (edge_w)
  );

  edge_demod_tick #(.DIV(CLK_PER_US)) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_w),
    .tick_o (tick_w)
  );

  edge_demod_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i ((state_q != ST_RECV) || win_end_w),
    .edge_i  (edge_w),
    .cnt_o   (cnt_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      nb_q    <= '0;
      bit_q   <= '0;
      dly_q   <= '0;
      us_q    <= '0;
      key_q   <= '0;
      acc_q   <= '0;
      crypt_q <= 1'b0;
      data_o  <= '0;
      nbits_o <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          nb_q    <= nb_req_w;
          dly_q   <= delay_us_i;
          key_q   <= key_i;
          crypt_q <= crypt_en_i;
          acc_q   <= '0;
          bit_q   <= '0;
          us_q    <= '0;
          if (delay_us_i != '0)      state_q <= ST_WAIT;
          else if (nb_req_w != '0)   state_q <= ST_RECV;
          else begin
            done_o  <= 1'b1;
            data_o  <= '0;
            nbits_o <= '0;
          end
        end
        ST_WAIT: if (tick_w) begin
          if (us_q == dly_q - 1'b1) begin
            us_q <= '0;
            if (nb_q == '0) begin
              state_q <= ST_IDLE;
              done_o  <= 1'b1;
              data_o  <= '0;
              nbits_o <= '0;
            end else begin
              state_q <= ST_RECV;
            end
          end else begin
            us_q <= us_q + 1'b1;
          end
        end
        ST_RECV: if (tick_w) begin
          if (us_q == WIN_END) begin
            us_q  <= '0;
            acc_q <= acc_nxt;
            bit_q <= bit_q + 1'b1;
            if (bit_q == nb_q - 1'b1) begin
              state_q <= ST_IDLE;
              done_o  <= 1'b1;
              data_o  <= acc_nxt;
              nbits_o <= nb_q;
            end
          end else begin
            us_q <= us_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_nbits_cap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nbits_o <= NB_CAP);

  assert_upper_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_o >> nbits_o) == '0);

  assert_start_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_w && start_i) |=> ($stable(nb_q) && $stable(key_q) && $stable(dly_q) && $stable(crypt_q)));
endmodule

// File: tb/test_edge_bit_demod.sv
module test_edge_bit_demod;
  localparam int P    = 4;
  localparam int WIN  = 100;
  localparam int MAXB = 32;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [5:0]  nbits_i = '0;
  logic [15:0] delay_us_i = '0;
  logic        crypt_en_i = 1'b0;
  logic [31:0] key_i = '0;
  logic        rx_i = 1'b0;
  logic [31:0] data_o;
  logic [5:0]  nbits_o;
  logic        done_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int cnt_tab[32];

  always #10 clk = ~clk;

  edge_bit_demod #(.CLK_PER_US(P)) i_edge_bit_demod (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .nbits_i(nbits_i),
    .delay_us_i(delay_us_i), .crypt_en_i(crypt_en_i), .key_i(key_i),
    .rx_i(rx_i), .data_o(data_o), .nbits_o(nbits_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Behavioural model: per-window counts -> expected word; done cycle from R2 formula
  task automatic run_frame(input int n_req, input int dly, input bit cr,
                           input logic [31:0] key, input bit poke, input string tag);
    int n_eff, exp_done, bad, m, r2, b, off, g;
    logic [31:0] exp_data, got_data;
    logic [5:0]  got_nb;
    bit one;
    n_eff = (n_req > MAXB) ? MAXB : n_req;
    exp_data = '0;
    for (int i = 0; i < n_eff; i++) begin
      m = (cnt_tab[i] > 127) ? 127 : cnt_tab[i];
      one = (m > 20) && (m < 60);
      exp_data[i] = one ^ (cr & key[i]);
    end
    exp_done = P * (dly + WIN * n_eff);
    bad = 0;
    got_data = '0;
    got_nb = '0;
    @(negedge clk);
    start_i = 1'b1; nbits_i = 6'(n_req); delay_us_i = 16'(dly);
    crypt_en_i = cr; key_i = key;
    for (int rel = 0; rel <= exp_done + 4; rel++) begin
      @(negedge clk);
      if (rel == 0) begin
        start_i = 1'b0; nbits_i = 6'd3; delay_us_i = 16'd7;
        crypt_en_i = ~cr; key_i = ~key;
      end
      if (poke && rel == exp_done / 2) start_i = 1'b1;
      if (poke && rel == exp_done / 2 + 1) start_i = 1'b0;
      if (done_o !== (rel == exp_done)) bad++;
      if (rel == exp_done) begin
        got_data = data_o;
        got_nb = nbits_o;
      end
      r2 = rel - P * dly;
      if (r2 >= 0 && r2 < P * WIN * n_eff) begin
        b = r2 / (P * WIN);
        off = r2 % (P * WIN);
        g = (cnt_tab[b] > 60) ? 2 : 6;
        if (off >= 20 && (off - 20) % g == 0 && (off - 20) / g < cnt_tab[b]) rx_i = ~rx_i;
      end
    end
    check(bad == 0, {tag, " R2 done timing (mismatching cycles)"}, bad, 0);
    check(got_data == exp_data, {tag, " data"}, got_data, exp_data);
    check(got_nb == 6'(n_eff), {tag, " R8 nbits"}, got_nb, n_eff);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(done_o == 1'b0, "R1 reset done", done_o, 0);
    check(data_o == '0, "R1 reset data", data_o, 0);
    check(nbits_o == '0, "R1 reset nbits", nbits_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    cnt_tab = '{default: 0};
    cnt_tab[0] = 42; cnt_tab[1] = 0; cnt_tab[2] = 42; cnt_tab[3] = 42;
    cnt_tab[4] = 10; cnt_tab[5] = 42;
    run_frame(6, 3, 1'b0, 32'h0, 1'b0, "R3 R6 basic frame");

    cnt_tab = '{default: 0};
    cnt_tab[0] = 20; cnt_tab[1] = 21; cnt_tab[2] = 59; cnt_tab[3] = 60;
    cnt_tab[4] = 0;  cnt_tab[5] = 1;  cnt_tab[6] = 42; cnt_tab[7] = 65;
    run_frame(8, 2, 1'b0, 32'h0, 1'b0, "R4 band limits");

    cnt_tab = '{default: 0};
    cnt_tab[0] = 170; cnt_tab[1] = 42;
    run_frame(2, 1, 1'b0, 32'h0, 1'b0, "R5 saturation");

    cnt_tab = '{default: 0};
    for (int i = 0; i < 12; i++) cnt_tab[i] = (i % 3 == 0) ? 42 : 5;
    run_frame(12, 5, 1'b1, 32'hFFFF_FABC, 1'b0, "R7 R9 descramble");
    run_frame(12, 5, 1'b0, 32'hFFFF_FABC, 1'b0, "R7 key ignored");

    cnt_tab = '{default: 42};
    run_frame(40, 0, 1'b0, 32'h0, 1'b0, "R8 clamp");

    cnt_tab = '{default: 0};
    cnt_tab[0] = 42; cnt_tab[1] = 42; cnt_tab[2] = 0; cnt_tab[3] = 42;
    run_frame(4, 1, 1'b0, 32'h0, 1'b0, "R9 upper bits zero");

    cnt_tab = '{default: 0};
    cnt_tab[0] = 42; cnt_tab[1] = 3; cnt_tab[2] = 42; cnt_tab[3] = 50; cnt_tab[4] = 30;
    run_frame(5, 2, 1'b0, 32'h0, 1'b1, "R10 start while busy");

    cnt_tab = '{default: 42};
    run_frame(0, 4, 1'b0, 32'h0, 1'b0, "R11 zero bits");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule